// File: doc/BRIEF.md
# Byte Queue with Direction-Aware Status Word

This block is a synchronous first-in first-out store for the bytes moving through a serial port. Its depth is a power of two, chosen by a log2 parameter. One instance sits on the transmit side, between the bus and the serializer. Another sits on the receive side, between the deserializer and the bus. A single parameter tells each instance which side it serves.

Beside the data path, the block produces a packed status word and two interrupt-ready flags. What they report depends on the direction:
- A receive-side queue counts the entries waiting to be read. Its flags ask for service when it is non-empty and when it is at least half full.
- A transmit-side queue counts the free slots. Its flags ask for data when it is not full and when at least half of it is free.

A write to a full queue without a read in the same cycle is lost. That loss sets a sticky error bit, which only reset or the synchronous clear input removes. The clear also empties the queue.

Top module: `uart_byte_fifo`

## Requirements
- R1: After reset, the queue is empty, `ovf_err` is 0 and `rd_data` is 0. After a `clr` cycle, the queue is empty and `ovf_err` is 0, and `rd_data` keeps its value.
- R2: Bytes leave in the order they were accepted. `rd_data` shows the oldest byte on the cycle after the edge that sampled `rd_en` high on a non-empty queue.
- R3: A write to a full queue with `rd_en` low is discarded and leaves the stored bytes untouched. It sets `ovf_err` on the next cycle. `ovf_err` then stays 1 until reset or `clr`.
- R4: A read of an empty queue with no write changes nothing: `rd_data`, the flags and the status word keep their values.
- R5: With `rd_en` and `wr_en` both high on a non-empty queue (full included), one byte leaves and one enters. The level is unchanged and no overflow is recorded. On an empty queue, the same pair only stores the byte.
- R6: `status[3 +: LG_DEPTH]` is the fill field. It holds the number of stored bytes when `IS_TX`=0 and the number of free slots when `IS_TX`=1, saturated at depth−1. It is up to date on the cycle after each accepting edge.
- R7: `half_flag` and `status[1]` equal the top bit of the fill field. They are 1 when at least half the depth is stored (`IS_TX`=0) or at least half is free (`IS_TX`=1).
- R8: `nz_flag` and `status[0]` are 1 when at least one byte is stored (`IS_TX`=0) or at least one slot is free (`IS_TX`=1). `status[2]` mirrors `ovf_err`.
- R9: `status[LG_DEPTH+3 +: 4]` always holds the value of `LG_DEPTH`. For example, 4 for a 16-entry queue.
- R10: `clr` overrides `wr_en` and `rd_en` in the same cycle: nothing is stored and nothing is read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of contents and error |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| rd_data | output | DATA_W | Registered oldest byte |
| status | output | LG_DEPTH+7 | {log2 depth, fill, ovf, half, nonzero} |
| half_flag | output | 1 | Half-level interrupt request |
| nz_flag | output | 1 | Nonzero interrupt request |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
Every result is due one clock after the edge that samples the strobes:
- `rd_data`, the level-driven flags and the fill field all come from registers loaded on that edge.
- `ovf_err` rises one cycle after the dropped write.

The bench drives each stimulus for exactly one edge and samples on the following falling edge. At that point the scoreboard monitor compares the byte popped on that edge, and every flag is recomputed from the bench's own count of stored bytes. A transmit-side and a receive-side instance run side by side on the same strobes, so each direction's report is checked against the same level.

// File: rtl/ufifo_pkg.sv
package ufifo_pkg;

  // Level as reported to software: stored bytes for receive, free slots
  // for transmit, clipped so that it fits an LG-bit field.
  function automatic logic [16:0] report_fill(input logic [16:0] level,
                                              input logic [16:0] depth,
                                              input logic        is_tx);
    logic [16:0] v;
    v = is_tx ? (depth - level) : level;
    if (v >= depth) v = depth - 17'd1;
    return v;
  endfunction

  // Next stored-byte count from the accepted events of one cycle.
  function automatic logic [16:0] next_level(input logic [16:0] level,
                                             input logic        push,
                                             input logic        pop);
    logic [16:0] n;
    n = level;
    if (push && !pop) n = level + 17'd1;
    if (pop && !push) n = level - 17'd1;
    return n;
  endfunction

endpackage

// File: rtl/ufifo_store.sv
module ufifo_store #(
  parameter int LG = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << LG;

  logic [DW-1:0] mem [DEPTH];
  logic [LG-1:0] wr_ptr;
  logic [LG-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      rdata  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        rdata  <= mem[rd_ptr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/ufifo_level.sv
module ufifo_level
  import ufifo_pkg::*;
#(
  parameter int LG    = 4,
  parameter bit IS_TX = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          drop,
  output logic [LG:0]   count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          half,
  output logic          nz,
  output logic [LG+6:0] status
);
  localparam int          DEPTH   = 1 << LG;
  localparam int          PAD     = 16 - LG;
  localparam logic [16:0] DEPTH_W = 17'(DEPTH);
  localparam logic [3:0]  LG_CODE = 4'(LG);

  logic [16:0]   lvl_wide;
  logic [16:0]   nxt_wide;
  logic [16:0]   rep_wide;
  logic [LG-1:0] fill;

  assign lvl_wide = {{PAD{1'b0}}, count};
  assign nxt_wide = next_level(lvl_wide, push, pop);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= nxt_wide[LG:0];
      if (drop) ovf <= 1'b1;
    end
  end

  assign full  = (count == LG'(0) + (LG+1)'(DEPTH));
  assign empty = (count == '0);

  assign rep_wide = report_fill(lvl_wide, DEPTH_W, IS_TX);
  assign fill     = rep_wide[LG-1:0];
  assign half     = fill[LG-1];

  generate
    if (IS_TX) begin : g_tx
      assign nz = !full;
    end else begin : g_rx
      assign nz = !empty;
    end
  endgenerate

  assign status = {LG_CODE, fill, ovf, half, nz};

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int LG_DEPTH = 4,
  parameter int DATA_W   = 8,
  parameter bit IS_TX    = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic [LG_DEPTH+6:0] status,
  output logic                half_flag,
  output logic                nz_flag,
  output logic                ovf_err
);
  logic [LG_DEPTH:0] count_q;
  logic              full;
  logic              empty;
  logic              push_ok;
  logic              pop_ok;
  logic              drop_wr;

  // Events for the checker: a read while full frees the slot this cycle.
  assign push_ok = wr_en && !clr && (!full || rd_en);
  assign pop_ok  = rd_en && !clr && !empty;
  assign drop_wr = wr_en && !clr && full && !rd_en;

  ufifo_store #(.LG(LG_DEPTH), .DW(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (wr_data),
    .rdata (rd_data)
  );

  ufifo_level #(.LG(LG_DEPTH), .IS_TX(IS_TX)) u_level (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .push   (push_ok),
    .pop    (pop_ok),
    .drop   (drop_wr),
    .count  (count_q),
    .full   (full),
    .empty  (empty),
    .ovf    (ovf_err),
    .half   (half_flag),
    .nz     (nz_flag),
    .status (status)
  );

endmodule

// File: rtl/ufifo_chk.sv
module ufifo_chk #(
  parameter int LG    = 4,
  parameter int DW    = 8,
  parameter bit IS_TX = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [LG:0]   lvl_count,
  input logic          drop_wr,
  input logic          ovf_err,
  input logic          nz_flag
);
  p_reset_clear_r1: assert property (@(posedge clk)
    (rst || clr) |=> (lvl_count == '0 && !ovf_err));

  p_drop_sets_err_r3: assert property (@(posedge clk) disable iff (rst)
    drop_wr |=> ovf_err);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !clr) |=> ovf_err);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !clr && lvl_count == '0) |=>
      ($stable(rd_data) && lvl_count == '0));

  p_both_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && !clr && lvl_count != '0) |=>
      ($stable(lvl_count) && !$rose(ovf_err)));

  p_nz_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (lvl_count == '0) |-> (IS_TX ? nz_flag : !nz_flag));

endmodule

bind uart_byte_fifo ufifo_chk #(.LG(LG_DEPTH), .DW(DATA_W), .IS_TX(IS_TX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .lvl_count (count_q),
  .drop_wr   (drop_wr),
  .ovf_err   (ovf_err),
  .nz_flag   (nz_flag)
);

// File: tb/uart_byte_fifo_tb.sv
module uart_byte_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LG = 4;
  localparam int D  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_rx, rd_tx;
  logic [10:0] st_rx, st_tx;
  logic        half_rx, half_tx, nz_rx, nz_tx, ovf_rx, ovf_tx;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_byte_fifo #(.LG_DEPTH(LG), .DATA_W(8), .IS_TX(1'b0)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_rx), .status(st_rx), .half_flag(half_rx),
    .nz_flag(nz_rx), .ovf_err(ovf_rx));

  uart_byte_fifo #(.LG_DEPTH(LG), .DATA_W(8), .IS_TX(1'b1)) u_dut_tx (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_tx), .status(st_tx), .half_flag(half_tx),
    .nz_flag(nz_tx), .ovf_err(ovf_tx));

  int errors = 0;
  int checks = 0;
  logic [7:0] mq[$];
  logic [7:0] exp_q[$];
  int   pend = 0;
  logic m_ovf = 1'b0;
  logic [7:0] last_rd = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each popped byte one cycle after its edge.
  always @(negedge clk) begin
    if (pend > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      pend--;
      chk(rd_rx == e, "R2 rx order", rd_rx, e);
      chk(rd_tx == e, "R2 tx order", rd_tx, e);
    end
  end

  task automatic check_flags();
    int n;
    int frx, ftx, srx, stx;
    n   = mq.size();
    frx = (n > D-1) ? D-1 : n;
    ftx = (D-n > D-1) ? D-1 : D-n;
    srx = (4 << 7) | (frx << 3) | (int'(m_ovf) << 2) | (int'(n >= D/2) << 1) | int'(n > 0);
    stx = (4 << 7) | (ftx << 3) | (int'(m_ovf) << 2) | (int'(D-n >= D/2) << 1) | int'(n < D);
    chk(st_rx[6:3] == frx[3:0], "R6 rx fill", st_rx[6:3], frx);
    chk(st_tx[6:3] == ftx[3:0], "R6 tx fill", st_tx[6:3], ftx);
    chk(half_rx == (n >= D/2), "R7 rx half", half_rx, n >= D/2);
    chk(half_tx == (D-n >= D/2), "R7 tx half", half_tx, D-n >= D/2);
    chk(nz_rx == (n > 0), "R8 rx nonzero", nz_rx, n > 0);
    chk(nz_tx == (n < D), "R8 tx nonzero", nz_tx, n < D);
    chk(ovf_rx == m_ovf && ovf_tx == m_ovf, "R3 overflow flag", ovf_rx, m_ovf);
    chk(st_rx[10:7] == 4'd4 && st_tx[10:7] == 4'd4, "R9 log2 field", st_rx[10:7], 4);
    chk(int'(st_rx) == srx, "R8 rx status word", st_rx, srx);
    chk(int'(st_tx) == stx, "R8 tx status word", st_tx, stx);
  endtask

  task automatic step(input bit wr, input logic [7:0] wd, input bit rd, input bit cl);
    bit was_empty;
    wr_en = wr; wr_data = wd; rd_en = rd; clr = cl;
    @(posedge clk);
    was_empty = (mq.size() == 0);
    if (cl) begin
      mq.delete();
      m_ovf = 1'b0;
    end else begin
      if (rd && !was_empty) begin
        last_rd = mq.pop_front();
        exp_q.push_back(last_rd);
        pend++;
        if (wr) mq.push_back(wd);
      end else if (wr) begin
        if (mq.size() < D) mq.push_back(wd);
        else m_ovf = 1'b1;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; clr = 1'b0;
    if (rd && (was_empty || cl)) begin
      chk(rd_rx == last_rd, "R4 R10 read data held", rd_rx, last_rd);
      chk(rd_tx == last_rd, "R4 R10 tx read data held", rd_tx, last_rd);
    end
    check_flags();
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd_cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(rd_rx == 8'h00 && rd_tx == 8'h00, "R1 reset read data", rd_rx, 0);
    check_flags();
    // R2 and R6: a few bytes in, two out
    step(1, 8'hA1, 0, 0);
    step(1, 8'hA2, 0, 0);
    step(1, 8'hA3, 0, 0);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 1, 0);
    // R5: both strobes on a partly filled queue
    step(1, 8'hB0, 1, 0);
    // R7: fill to full, crossing the half mark
    for (int i = 0; mq.size() < D; i++) step(1, 8'(8'h10 + i), 0, 0);
    // R3: dropped write, then the error stays set
    step(1, 8'hEE, 0, 0);
    step(0, 8'h00, 0, 0);
    // R5: both strobes while full
    step(1, 8'h55, 1, 0);
    // R2: drain; the dropped byte must not appear
    while (mq.size() > 0) step(0, 8'h00, 1, 0);
    // R4: reads of an empty queue
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 1, 0);
    // R5: both strobes on empty store the byte only
    step(1, 8'hC3, 1, 0);
    step(1, 8'hC4, 0, 0);
    // R10 and R1: clear wins over both strobes and drops the error
    step(1, 8'hDD, 1, 1);
    step(1, 8'h77, 0, 0);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);
    // R1: reset with data inside
    step(1, 8'h99, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    mq.delete(); m_ovf = 1'b0; last_rd = 8'h00;
    @(negedge clk);
    rst = 1'b0;
    chk(rd_rx == 8'h00, "R1 reset clears read data", rd_rx, 0);
    check_flags();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule